// File: doc/BRIEF.md
# Multi-Width Integer Adder/Subtracter with Status Flags

This is a purely combinational arithmetic unit for a processor datapath. It takes a destination operand, a source operand, the current carry flag, an operation code and an operand-size code, and in the same cycle returns the arithmetic result and six status flags. It also returns a write mask that tells the surrounding flag register which flags to update. The unit works on byte, halfword or word operands. All arithmetic is done at the selected width, and every flag is taken from that width.

Subtraction is done by adding the inverted source with a carry-in. The carry and auxiliary-carry flags are then inverted, so they read as borrows. Increment and decrement do not touch the carry flag. Negate reports a carry whenever its operand is nonzero. Two further operation codes only force the carry flag to one or to zero.

Top module: `ialu_flags`

## Requirements
- R1: The operation codes on `op_i` are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 increment, 5 decrement, 6 negate, 7 set carry, 8 clear carry. The size codes on `size_i` are: 00 for 8 bits, 01 for 16 bits, 1x for 32 bits. `result_o` is the result truncated to the selected width. All bits above that width are zero, whatever the upper bits of the operands are.
- R2: The carry flag is bit 0 of `flags_o`. For add it is the carry out of the most significant bit (MSB) of the selected width. For subtract it is the inverse of that carry out, so it is set exactly when the destination is unsigned-smaller than the source.
- R3: The overflow flag is bit 5 of `flags_o`. It equals the carry out of the MSB XOR the carry into the MSB. An add of two operands whose signs differ never sets it.
- R4: The auxiliary-carry flag is bit 2 of `flags_o`. It is set on a carry out of bit 3 into bit 4 (for add, add-with-carry, increment) or on a borrow from bit 4 into bit 3 (for subtract, subtract-with-borrow, decrement, negate).
- R5: The parity flag is bit 1 of `flags_o`. It is set when bits 7..0 of the result hold an even number of ones, at every operand width.
- R6: The zero flag is bit 3 of `flags_o` and is set when the width-truncated result is all zeros. The sign flag is bit 4 of `flags_o` and copies the result MSB at the selected width.
- R7: Add-with-carry yields dest + src + `cf_i`. Subtract-with-borrow yields dest − src − `cf_i`. Their carry flags follow R2 for the whole three-term operation.
- R8: Add, add-with-carry, subtract, subtract-with-borrow and negate drive `flag_we_o` to 6'b111111. Increment and decrement yield dest ± 1 and drive `flag_we_o` to 6'b111110, leaving the carry flag unwritten.
- R9: Negate yields 0 − dest at the selected width and sets the carry flag exactly when the width-truncated destination is nonzero.
- R10: Set carry and clear carry give a zero result and `flag_we_o` = 6'b000001. `flags_o` is 6'b000001 for set carry and 6'b000000 for clear carry.
- R11: Operation codes 9 to 15 give a zero result, zero flags and a zero write mask. Any flag bit whose write-enable is clear reads as 0 in `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dest_i | input | DATA_W | Destination operand |
| src_i | input | DATA_W | Source operand |
| cf_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand-size code |
| result_o | output | DATA_W | Width-truncated result, upper bits zero |
| flags_o | output | 6 | {OF, SF, ZF, AF, PF, CF} |
| flag_we_o | output | 6 | Per-flag write enable, same bit order |

## Verification
The assertions are immediate checks evaluated whenever the inputs change. They assume each input combination is held steady long enough for the outputs to settle before it is judged. They also assume every input is a known 0 or 1; an unknown size or opcode would make the expected width mask meaningless.

The bench changes inputs only on rising clock edges and compares the outputs at the falling edge, so every vector has settled before it is compared. It drives every input bit from fully defined values, including unused opcodes, the spare size code and garbage in operand bits above the selected width.

// File: rtl/ialu_flags_pkg.sv
package ialu_flags_pkg;

   localparam int NFLAGS = 6;
   localparam int FLG_CF = 0;
   localparam int FLG_PF = 1;
   localparam int FLG_AF = 2;
   localparam int FLG_ZF = 3;
   localparam int FLG_SF = 4;
   localparam int FLG_OF = 5;

   localparam logic [NFLAGS-1:0] WE_ALL    = 6'b111111;
   localparam logic [NFLAGS-1:0] WE_NO_CF  = 6'b111110;
   localparam logic [NFLAGS-1:0] WE_CF     = 6'b000001;
   localparam logic [NFLAGS-1:0] WE_NONE   = 6'b000000;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBB  = 4'd3,
      OP_INC  = 4'd4,
      OP_DEC  = 4'd5,
      OP_NEG  = 4'd6,
      OP_SETC = 4'd7,
      OP_CLRC = 4'd8
   } alu_op_e;

   typedef enum logic [1:0] {
      BSRC_SRC  = 2'd0,
      BSRC_ONE  = 2'd1,
      BSRC_DEST = 2'd2
   } bsrc_e;

   typedef struct packed {
      logic              arith;
      logic              zero_a;
      bsrc_e             bsrc;
      logic              invert_b;
      logic              carry_in;
      logic              borrow;
      logic              force_cf;
      logic              cf_val;
      logic [NFLAGS-1:0] we;
   } alu_ctl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
   import ialu_flags_pkg::*;
(
   input  logic [3:0] op_i,
   input  logic       cf_i,
   output alu_ctl_t   ctl_o
);

   always_comb begin
      ctl_o          = '0;
      ctl_o.bsrc     = BSRC_SRC;
      ctl_o.we       = WE_NONE;
      case (op_i)
         OP_ADD: begin
            ctl_o.arith = 1'b1;
            ctl_o.we    = WE_ALL;
         end
         OP_ADC: begin
            ctl_o.arith    = 1'b1;
            ctl_o.carry_in = cf_i;
            ctl_o.we       = WE_ALL;
         end
         OP_SUB: begin
            ctl_o.arith    = 1'b1;
            ctl_o.invert_b = 1'b1;
            ctl_o.carry_in = 1'b1;
            ctl_o.borrow   = 1'b1;
            ctl_o.we       = WE_ALL;
         end
         OP_SBB: begin
            ctl_o.arith    = 1'b1;
            ctl_o.invert_b = 1'b1;
            ctl_o.carry_in = ~cf_i;
            ctl_o.borrow   = 1'b1;
            ctl_o.we       = WE_ALL;
         end
         OP_INC: begin
            ctl_o.arith = 1'b1;
            ctl_o.bsrc  = BSRC_ONE;
            ctl_o.we    = WE_NO_CF;
         end
         OP_DEC: begin
            ctl_o.arith    = 1'b1;
            ctl_o.bsrc     = BSRC_ONE;
            ctl_o.invert_b = 1'b1;
            ctl_o.carry_in = 1'b1;
            ctl_o.borrow   = 1'b1;
            ctl_o.we       = WE_NO_CF;
         end
         OP_NEG: begin
            ctl_o.arith    = 1'b1;
            ctl_o.zero_a   = 1'b1;
            ctl_o.bsrc     = BSRC_DEST;
            ctl_o.invert_b = 1'b1;
            ctl_o.carry_in = 1'b1;
            ctl_o.borrow   = 1'b1;
            ctl_o.we       = WE_ALL;
         end
         OP_SETC: begin
            ctl_o.force_cf = 1'b1;
            ctl_o.cf_val   = 1'b1;
            ctl_o.we       = WE_CF;
         end
         OP_CLRC: begin
            ctl_o.force_cf = 1'b1;
            ctl_o.we       = WE_CF;
         end
         default: begin
            ctl_o.we = WE_NONE;
         end
      endcase
   end

endmodule

// File: rtl/alu_size_sel.sv
module alu_size_sel #(
   parameter int BYTE_W = 8,
   parameter int HALF_W = 16,
   parameter int DATA_W = 32
) (
   input  logic [1:0]        size_i,
   output logic [DATA_W-1:0] mask_o,
   output logic [2:0]        sel_o
);

   localparam int NSIZES = 3;
   localparam int SZ_TAB [NSIZES] = '{BYTE_W, HALF_W, DATA_W};

   logic [DATA_W-1:0] mask_tab [NSIZES];

   for (genvar g = 0; g < NSIZES; g++) begin : g_mask
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign mask_tab[g][b] = (b < SZ_TAB[g]) ? 1'b1 : 1'b0;
      end
   end

   always_comb begin
      unique case (size_i)
         2'b00:   sel_o = 3'b001;
         2'b01:   sel_o = 3'b010;
         default: sel_o = 3'b100;
      endcase
   end

   always_comb begin
      mask_o = '0;
      for (int k = 0; k < NSIZES; k++) begin
         if (sel_o[k]) mask_o = mask_o | mask_tab[k];
      end
   end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int BYTE_W = 8,
   parameter int HALF_W = 16,
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic [2:0]        sel_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o,
   output logic              cmsb_o,
   output logic              cnib_o,
   output logic              msb_o
);

   localparam int NSIZES = 3;
   localparam int SZ_TAB [NSIZES] = '{BYTE_W, HALF_W, DATA_W};

   logic [DATA_W:0]   full;
   logic [NSIZES-1:0] cout_tab;
   logic [NSIZES-1:0] cmsb_tab;
   logic [NSIZES-1:0] msb_tab;

   assign full  = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
   assign sum_o = full[DATA_W-1:0];

   for (genvar g = 0; g < NSIZES; g++) begin : g_tap
      assign cout_tab[g] = full[SZ_TAB[g]];
      assign cmsb_tab[g] = full[SZ_TAB[g]-1] ^ a_i[SZ_TAB[g]-1] ^ b_i[SZ_TAB[g]-1];
      assign msb_tab[g]  = full[SZ_TAB[g]-1];
   end

   assign cout_o = |(cout_tab & sel_i);
   assign cmsb_o = |(cmsb_tab & sel_i);
   assign msb_o  = |(msb_tab & sel_i);
   assign cnib_o = full[4] ^ a_i[4] ^ b_i[4];

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
   import ialu_flags_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] res_i,
   input  logic              cout_i,
   input  logic              cmsb_i,
   input  logic              cnib_i,
   input  logic              msb_i,
   input  logic              borrow_i,
   input  logic              force_cf_i,
   input  logic              cf_val_i,
   input  logic [NFLAGS-1:0] we_i,
   output logic [NFLAGS-1:0] flags_o
);

   logic [NFLAGS-1:0] raw;

   always_comb begin
      raw         = '0;
      raw[FLG_CF] = borrow_i ? ~cout_i : cout_i;
      raw[FLG_AF] = borrow_i ? ~cnib_i : cnib_i;
      raw[FLG_OF] = cout_i ^ cmsb_i;
      raw[FLG_SF] = msb_i;
      raw[FLG_ZF] = (res_i == '0);
      raw[FLG_PF] = ~(^res_i[7:0]);
      if (force_cf_i) begin
         raw         = '0;
         raw[FLG_CF] = cf_val_i;
      end
   end

   assign flags_o = raw & we_i;

endmodule

// File: rtl/ialu_flags.sv
module ialu_flags
   import ialu_flags_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int HALF_W = 16,
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] dest_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic              cf_i,
   input  logic [3:0]        op_i,
   input  logic [1:0]        size_i,
   output logic [DATA_W-1:0] result_o,
   output logic [5:0]        flags_o,
   output logic [5:0]        flag_we_o
);

   if (BYTE_W < 8) begin : g_bad_byte
      $error("BYTE_W must cover the parity byte");
   end
   if (HALF_W <= BYTE_W) begin : g_bad_half
      $error("HALF_W must exceed BYTE_W");
   end
   if (DATA_W <= HALF_W) begin : g_bad_data
      $error("DATA_W must exceed HALF_W");
   end

   alu_ctl_t          ctl;
   logic [DATA_W-1:0] wmask;
   logic [2:0]        wsel;
   logic [DATA_W-1:0] opa;
   logic [DATA_W-1:0] opb;
   logic [DATA_W-1:0] braw;
   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] res;
   logic              cout;
   logic              cmsb;
   logic              cnib;
   logic              msb;

   alu_op_decode u_dec (
      .op_i  (op_i),
      .cf_i  (cf_i),
      .ctl_o (ctl)
   );

   alu_size_sel #(.BYTE_W(BYTE_W), .HALF_W(HALF_W), .DATA_W(DATA_W)) u_size (
      .size_i (size_i),
      .mask_o (wmask),
      .sel_o  (wsel)
   );

   always_comb begin
      unique case (ctl.bsrc)
         BSRC_ONE:  braw = {{(DATA_W-1){1'b0}}, 1'b1};
         BSRC_DEST: braw = dest_i;
         default:   braw = src_i;
      endcase
      opa = ctl.zero_a ? '0 : (dest_i & wmask);
      opb = (ctl.invert_b ? ~braw : braw) & wmask;
   end

   alu_adder #(.BYTE_W(BYTE_W), .HALF_W(HALF_W), .DATA_W(DATA_W)) u_add (
      .a_i    (opa),
      .b_i    (opb),
      .cin_i  (ctl.carry_in),
      .sel_i  (wsel),
      .sum_o  (sum),
      .cout_o (cout),
      .cmsb_o (cmsb),
      .cnib_o (cnib),
      .msb_o  (msb)
   );

   assign res = ctl.arith ? (sum & wmask) : '0;

   alu_flag_gen #(.DATA_W(DATA_W)) u_flg (
      .res_i      (res),
      .cout_i     (cout),
      .cmsb_i     (cmsb),
      .cnib_i     (cnib),
      .msb_i      (msb),
      .borrow_i   (ctl.borrow),
      .force_cf_i (ctl.force_cf),
      .cf_val_i   (ctl.cf_val),
      .we_i       (ctl.we),
      .flags_o    (flags_o)
   );

   assign result_o  = res;
   assign flag_we_o = ctl.we;

endmodule

// File: rtl/ialu_flags_chk.sv
module ialu_flags_chk #(
   parameter int BYTE_W = 8,
   parameter int HALF_W = 16,
   parameter int DATA_W = 32
) (
   input logic [DATA_W-1:0] dest_i,
   input logic [DATA_W-1:0] src_i,
   input logic              cf_i,
   input logic [3:0]        op_i,
   input logic [1:0]        size_i,
   input logic [DATA_W-1:0] result_o,
   input logic [5:0]        flags_o,
   input logic [5:0]        flag_we_o
);

   logic [DATA_W-1:0] m;
   int                w;

   always_comb begin
      w = (size_i == 2'b00) ? BYTE_W : (size_i == 2'b01) ? HALF_W : DATA_W;
      m = '0;
      for (int k = 0; k < DATA_W; k++) m[k] = (k < w);
   end

   always_comb begin
      // R1
      upper_bits_chk: assert ((result_o & ~m) == '0);
      // R11
      masked_flag_chk: assert ((flags_o & ~flag_we_o) == 6'b0);
      // R6
      if (flag_we_o[3]) zero_flag_chk: assert (flags_o[3] == (result_o == '0));
      // R5
      if (flag_we_o[1]) parity_chk: assert (flags_o[1] == ~(^result_o[7:0]));
      // R8
      if (op_i == 4'd4 || op_i == 4'd5) incdec_no_cf_chk: assert (flag_we_o == 6'b111110);
      // R9
      if (op_i == 4'd6) neg_carry_chk: assert (flags_o[0] == ((dest_i & m) != '0));
      // R3
      if (op_i == 4'd0 && (((dest_i ^ src_i) & m & ~(m >> 1)) != '0))
         no_overflow_chk: assert (!flags_o[5]);
      // R7
      if (op_i == 4'd1 && (dest_i & m) == '0 && (src_i & m) == '0)
         adc_cin_chk: assert (result_o == {{(DATA_W-1){1'b0}}, cf_i});
      // R10
      if (op_i == 4'd7 || op_i == 4'd8)
         carry_op_chk: assert (flag_we_o == 6'b000001 && result_o == '0);
   end

endmodule

bind ialu_flags ialu_flags_chk #(.BYTE_W(BYTE_W), .HALF_W(HALF_W), .DATA_W(DATA_W)) u_chk (
   .dest_i    (dest_i),
   .src_i     (src_i),
   .cf_i      (cf_i),
   .op_i      (op_i),
   .size_i    (size_i),
   .result_o  (result_o),
   .flags_o   (flags_o),
   .flag_we_o (flag_we_o)
);

// File: tb/ialu_flags_test.sv
module ialu_flags_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] dest = '0;
   logic [31:0] src = '0;
   logic        cf = 1'b0;
   logic [3:0]  op = '0;
   logic [1:0]  size = '0;
   logic [31:0] result;
   logic [5:0]  flags;
   logic [5:0]  we;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ialu_flags uut (
      .dest_i    (dest),
      .src_i     (src),
      .cf_i      (cf),
      .op_i      (op),
      .size_i    (size),
      .result_o  (result),
      .flags_o   (flags),
      .flag_we_o (we)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic int popc8(longint v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += int'((v >> i) & 1);
      return n;
   endfunction

   task automatic model(input int o, input int sz, input longint d, input longint s,
                        input bit c, output longint r, output bit [5:0] f, output bit [5:0] fw);
      int     wd;
      longint msk, half, x, y, cc, sx, sy, ex, t;
      bit     sub;
      wd   = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
      msk  = (longint'(1) << wd) - 1;
      half = longint'(1) << (wd - 1);
      d    = d & msk;
      s    = s & msk;
      f    = '0;
      r    = 0;
      x = d; y = s; cc = 0; sub = 0;
      case (o)
         0: ;
         1: cc = longint'(c);
         2: sub = 1;
         3: begin sub = 1; cc = longint'(c); end
         4: y = 1;
         5: begin y = 1; sub = 1; end
         6: begin x = 0; y = d; sub = 1; end
         7: begin fw = 6'b000001; f = 6'b000001; return; end
         8: begin fw = 6'b000001; return; end
         default: begin fw = '0; return; end
      endcase
      fw = (o == 4 || o == 5) ? 6'b111110 : 6'b111111;
      sx = (x >= half) ? x - (msk + 1) : x;
      sy = (y >= half) ? y - (msk + 1) : y;
      if (!sub) begin
         t    = x + y + cc;
         f[0] = (t > msk);
         f[2] = ((x & 15) + (y & 15) + cc) > 15;
         ex   = sx + sy + cc;
      end else begin
         t    = x - y - cc;
         f[0] = (x < y + cc);
         f[2] = (x & 15) < ((y & 15) + cc);
         ex   = sx - sy - cc;
      end
      r    = t & msk;
      f[5] = (ex >= half) || (ex < -half);
      f[4] = ((r >> (wd - 1)) & 1) != 0;
      f[3] = (r == 0);
      f[1] = (popc8(r) % 2) == 0;
      f    = f & fw;
   endtask

   function automatic string res_tag(int o);
      if (o == 6) return "R9";
      if (o == 7 || o == 8) return "R10";
      if (o > 8) return "R11";
      if (o == 1 || o == 3) return "R7";
      return "R1";
   endfunction

   task automatic check_bit(input string tag, input string nm, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s op=%0d size=%0d d=%h s=%h c=%0d actual=%0d expected=%0d",
                  tag, nm, op, size, dest, src, cf, act, exp);
      end
   endtask

   task automatic apply(input int o, input int sz, input logic [31:0] d,
                        input logic [31:0] s, input bit c);
      longint    er;
      bit [5:0]  ef, ew;
      string     ft;
      @(posedge clk);
      op = 4'(o); size = 2'(sz); dest = d; src = s; cf = c;
      model(o, sz, longint'(d), longint'(s), c, er, ef, ew);
      @(negedge clk);
      checks++;
      if (longint'(result) != er) begin
         errors++;
         $display("FAIL %s result op=%0d size=%0d d=%h s=%h actual=%h expected=%h",
                  res_tag(o), o, sz, d, s, result, er[31:0]);
      end
      checks++;
      if (we !== ew) begin
         errors++;
         $display("FAIL %s write-mask op=%0d actual=%b expected=%b",
                  (o == 4 || o == 5) ? "R8" : res_tag(o), o, we, ew);
      end
      ft = (o == 1 || o == 3) ? "R7" : (o == 6) ? "R9" : (o > 6) ? res_tag(o) : "R2";
      check_bit(ft,   "carry",    flags[0], ef[0]);
      check_bit("R5", "parity",   flags[1], ef[1]);
      check_bit("R4", "auxcarry", flags[2], ef[2]);
      check_bit("R6", "zero",     flags[3], ef[3]);
      check_bit("R6", "sign",     flags[4], ef[4]);
      check_bit("R3", "overflow", flags[5], ef[5]);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: all-zero inputs, byte add of zeros -> ZF and PF set
      @(negedge clk);
      checks++;
      if (result !== 32'h0 || flags !== 6'b001010 || we !== 6'b111111) begin
         errors++;
         $display("FAIL R6 reset state actual=%h/%b/%b expected=0/001010/111111",
                  result, flags, we);
      end
      // R2 R6: byte add wrapping to zero with garbage upper bits (R1)
      apply(0, 0, 32'hABCD_EFFF, 32'h1234_5601, 0);
      // R3: signed overflow in byte add 7F+1
      apply(0, 0, 32'h0000_007F, 32'h0000_0001, 0);
      // R3 R4: byte subtract 26-95
      apply(2, 0, 32'h0000_0026, 32'h0000_0095, 0);
      // R2: word add carry out
      apply(0, 2, 32'hFFFF_FFFF, 32'h0000_0001, 0);
      // R3: mixed-sign half add
      apply(0, 1, 32'h0000_7FFF, 32'h0000_8000, 0);
      // R5: parity on low byte at 32-bit width
      apply(0, 2, 32'h0F00_0003, 32'h0000_0000, 0);
      // R7: adc / sbb with incoming carry
      apply(1, 0, 32'h0000_00FF, 32'h0000_0000, 1);
      apply(3, 1, 32'h0000_0000, 32'h0000_0000, 1);
      apply(3, 0, 32'h0000_0010, 32'h0000_00FF, 1);
      // R8: inc/dec leave carry unwritten
      apply(4, 0, 32'h0000_00FF, 32'h0, 1);
      apply(5, 1, 32'h0000_0000, 32'h0, 0);
      apply(5, 0, 32'h0000_0080, 32'h0, 0);
      // R9: negate zero, min-negative, ordinary value
      apply(6, 0, 32'hFFFF_FF00, 32'h0, 1);
      apply(6, 0, 32'h0000_0080, 32'h0, 0);
      apply(6, 2, 32'h0000_0001, 32'h0, 0);
      // R10: set and clear carry
      apply(7, 2, 32'h1234_5678, 32'h1, 0);
      apply(8, 0, 32'h1234_5678, 32'h1, 1);
      // R11: undefined opcodes
      for (int k = 9; k < 16; k++) apply(k, k % 4, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1);
      // spare size code behaves as 32 bits (R1)
      apply(0, 3, 32'h8000_0000, 32'h8000_0000, 0);
      for (int n = 0; n < 4000; n++) begin
         int          o, sz;
         logic [31:0] d, s;
         o  = int'($urandom % 11);
         if (o >= 9) o = 9 + int'($urandom % 7);
         sz = int'($urandom % 4);
         d  = $urandom;
         s  = $urandom;
         if (n % 5 == 0) d = (n % 2 == 0) ? 32'hFFFF_FFFF : 32'h8000_0080;
         if (n % 7 == 0) s = d;
         apply(o, sz, d, s, 1'($urandom));
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule